// File: doc/BRIEF.md
# Reserved-Instruction Trap Detector

This block watches each arithmetic/logic instruction word as it is issued on a 16-bit word-addressed minicomputer. Some encodings combine the "do not write the result back" bit with the "never skip" test. Such a word has no effect at all, so these encodings are reserved as a trap hook for a larger sibling instruction set. When the block sees one, it blocks normal execution of that word. The word then changes no accumulator and no carry.

After blocking the word, the block runs a two-cycle memory sequence. First it writes the address of the trapping instruction to the save word at octal 46. Then it reads the vector word at octal 47 and loads that value into the program counter. This is an indirect jump through the vector.

The source-accumulator, destination-accumulator and trap-number fields of the trapping word are latched. They are held for the handler until the next trap. Every other instruction is passed on for normal execution. This includes a no-load word with a non-zero skip test, which is an ordinary test-and-skip.

Top module: `rtrap_detect`

## Requirements
- R1: Bit positions count from the LSB. A word is a trap when bit 15 (arithmetic/logic class) is 1, bit 3 (no-load) is 1 and bits 2:0 (skip test) are 000. `trap_hit` is 1, in the same cycle, exactly when `ins_valid` is 1, the block is idle and the word is a trap.
- R2: `exec_ok` is 1 exactly when `ins_valid` is 1, the block is idle and the word is not a trap. This includes no-load words whose skip test is non-zero. `exec_ok` and `trap_hit` are never 1 together.
- R3: On the clock edge where `trap_hit` is 1, three fields of the word are latched and held until the next trap. `fld_src` takes bits 14:13, `fld_dst` takes bits 12:11 and `fld_num` takes bits 10:4.
- R4: The cycle after a trap is accepted, the block issues a write. `mem_req` is 1, `mem_we` is 1, `mem_addr` is octal 46 and `mem_wdata` is the trapping `ins_addr`, zero-extended. These values are held until a cycle with `mem_ack` set.
- R5: The cycle after the write is acknowledged, the block issues a read. `mem_req` is 1, `mem_we` is 0 and `mem_addr` is octal 47. These values are held until `mem_ack`.
- R6: The cycle after the read is acknowledged, `pc_load` is 1 for exactly one cycle. In that cycle `pc_value` equals the acknowledged `mem_rdata[AW-1:0]`. The block is idle on the following cycle.
- R7: `busy` is 1 from the cycle after acceptance through the `pc_load` cycle. While `busy` is 1, the instruction inputs are ignored: `trap_hit` and `exec_ok` stay 0 and the latched fields do not change.
- R8: After reset, `busy`, `mem_req`, `pc_load` and all latched fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | An instruction is presented this cycle |
| ins_word | input | 16 | Instruction word |
| ins_addr | input | AW | Address of the presented instruction |
| trap_hit | output | 1 | Presented word is accepted as a trap |
| exec_ok | output | 1 | Presented word may execute normally |
| busy | output | 1 | Trap sequence in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 16 | Write data (saved instruction address) |
| mem_ack | input | 1 | Memory has completed the current access |
| mem_rdata | input | 16 | Read data (vector word) |
| pc_load | output | 1 | Load program counter this cycle |
| pc_value | output | AW | New program counter value |
| fld_src | output | 2 | Latched source accumulator field |
| fld_dst | output | 2 | Latched destination accumulator field |
| fld_num | output | 7 | Latched trap number |

## Verification
`trap_hit` and `exec_ok` are combinational, so the bench checks them 1 ns after the inputs change, within the same cycle. The write request appears one edge after acceptance, and the read request one edge after the write acknowledge. `pc_load` appears one edge after the read acknowledge, and idle follows one edge later. The latched fields are valid one edge after acceptance. The bench drives every input and samples every output 1 ns after a rising edge, and it counts edges explicitly for each of these delays. Memory wait states vary from zero to two cycles, and the bench checks that the request is held steady on each wait cycle.

// File: rtl/rtrap_pkg.sv
package rtrap_pkg;

   localparam int WORD_W     = 16;
   localparam int POS_CLASS  = 15;
   localparam int POS_SRC    = 13;
   localparam int POS_DST    = 11;
   localparam int POS_NUM    = 4;
   localparam int NUM_W      = 7;
   localparam int POS_NOLOAD = 3;
   localparam int SKIP_W     = 3;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SAVE  = 2'd1,
      ST_FETCH = 2'd2,
      ST_LOAD  = 2'd3
   } seq_state_t;

   typedef struct packed {
      logic [1:0]       src;
      logic [1:0]       dst;
      logic [NUM_W-1:0] num;
   } trap_fields_t;

   function automatic trap_fields_t split_fields(input logic [WORD_W-1:0] w);
      trap_fields_t f;
      f.src = w[POS_SRC +: 2];
      f.dst = w[POS_DST +: 2];
      f.num = w[POS_NUM +: NUM_W];
      return f;
   endfunction

   function automatic logic is_reserved(input logic [WORD_W-1:0] w);
      return w[POS_CLASS] && w[POS_NOLOAD] && (w[SKIP_W-1:0] == '0);
   endfunction

endpackage

// File: rtl/rtrap_decode.sv
module rtrap_decode
   import rtrap_pkg::*;
(
   input  logic              valid,
   input  logic [WORD_W-1:0] word,
   input  logic              idle,
   output logic              hit,
   output logic              run,
   output trap_fields_t      fields
);

   logic reserved;

   always_comb begin
      reserved = is_reserved(word);
      hit      = valid && idle && reserved;
      run      = valid && idle && !reserved;
      fields   = split_fields(word);
   end

endmodule

// File: rtl/rtrap_fields.sv
module rtrap_fields
   import rtrap_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  trap_fields_t d,
   output trap_fields_t q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= d;
      end
   end

endmodule

// File: rtl/rtrap_seq.sv
module rtrap_seq
   import rtrap_pkg::*;
#(
   parameter int AW       = 15,
   parameter int SAVE_LOC = 'o46,
   parameter int VEC_LOC  = 'o47
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [AW-1:0]     start_addr,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              idle,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              pc_load,
   output logic [AW-1:0]     pc_value
);

   localparam logic [AW-1:0] SAVE_A = SAVE_LOC[AW-1:0];
   localparam logic [AW-1:0] VEC_A  = VEC_LOC[AW-1:0];
   localparam int            PAD_W  = WORD_W - AW;

   seq_state_t    state_q;
   seq_state_t    state_d;
   logic [AW-1:0] saved_q;
   logic [AW-1:0] pc_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (start)   state_d = ST_SAVE;
         ST_SAVE:  if (mem_ack) state_d = ST_FETCH;
         ST_FETCH: if (mem_ack) state_d = ST_LOAD;
         ST_LOAD:               state_d = ST_IDLE;
         default:               state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         saved_q <= '0;
         pc_q    <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start) begin
            saved_q <= start_addr;
         end
         if (state_q == ST_FETCH && mem_ack) begin
            pc_q <= mem_rdata[AW-1:0];
         end
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         logic unused_rdata_hi;
         assign unused_rdata_hi = ^mem_rdata[WORD_W-1:AW];
         assign mem_wdata = {{PAD_W{1'b0}}, saved_q};
      end else begin : g_nopad
         assign mem_wdata = saved_q;
      end
   endgenerate

   always_comb begin
      idle     = (state_q == ST_IDLE);
      mem_req  = (state_q == ST_SAVE) || (state_q == ST_FETCH);
      mem_we   = (state_q == ST_SAVE);
      mem_addr = (state_q == ST_SAVE) ? SAVE_A : VEC_A;
      pc_load  = (state_q == ST_LOAD);
      pc_value = pc_q;
   end

endmodule

// File: rtl/rtrap_detect.sv
module rtrap_detect
   import rtrap_pkg::*;
#(
   parameter int AW       = 15,
   parameter int SAVE_LOC = 'o46,
   parameter int VEC_LOC  = 'o47
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_valid,
   input  logic [15:0]       ins_word,
   input  logic [AW-1:0]     ins_addr,
   output logic              trap_hit,
   output logic              exec_ok,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [15:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [15:0]       mem_rdata,
   output logic              pc_load,
   output logic [AW-1:0]     pc_value,
   output logic [1:0]        fld_src,
   output logic [1:0]        fld_dst,
   output logic [6:0]        fld_num
);

   generate
      if (AW < 8 || AW > WORD_W - 1) begin : g_bad_aw
         $error("rtrap_detect: AW must lie in 8..15");
      end
      if (SAVE_LOC < 0 || SAVE_LOC >= (1 << AW) || VEC_LOC < 0 || VEC_LOC >= (1 << AW)) begin : g_bad_loc
         $error("rtrap_detect: save/vector location outside address space");
      end
      if (SAVE_LOC == VEC_LOC) begin : g_same_loc
         $error("rtrap_detect: save and vector locations must differ");
      end
   endgenerate

   logic         idle;
   logic         hit;
   logic         run;
   trap_fields_t dec_fields;
   trap_fields_t held_fields;

   rtrap_decode i_decode (
      .valid  (ins_valid),
      .word   (ins_word),
      .idle   (idle),
      .hit    (hit),
      .run    (run),
      .fields (dec_fields)
   );

   rtrap_fields i_fields (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (hit),
      .d     (dec_fields),
      .q     (held_fields)
   );

   rtrap_seq #(
      .AW       (AW),
      .SAVE_LOC (SAVE_LOC),
      .VEC_LOC  (VEC_LOC)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (hit),
      .start_addr (ins_addr),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .idle       (idle),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .pc_load    (pc_load),
      .pc_value   (pc_value)
   );

   always_comb begin
      trap_hit = hit;
      exec_ok  = run;
      busy     = !idle;
      fld_src  = held_fields.src;
      fld_dst  = held_fields.dst;
      fld_num  = held_fields.num;
   end

endmodule

// File: rtl/rtrap_checker.sv
module rtrap_checker #(
   parameter int AW       = 15,
   parameter int SAVE_LOC = 'o46,
   parameter int VEC_LOC  = 'o47
) (
   input logic          clk,
   input logic          rst_n,
   input logic [15:0]   ins_word,
   input logic [AW-1:0] ins_addr,
   input logic          trap_hit,
   input logic          exec_ok,
   input logic          busy,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [15:0]   mem_wdata,
   input logic          mem_ack,
   input logic [15:0]   mem_rdata,
   input logic          pc_load,
   input logic [AW-1:0] pc_value,
   input logic [1:0]    fld_src,
   input logic [1:0]    fld_dst,
   input logic [6:0]    fld_num
);

   localparam logic [AW-1:0] SAVE_A = SAVE_LOC[AW-1:0];
   localparam logic [AW-1:0] VEC_A  = VEC_LOC[AW-1:0];

   assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(trap_hit && exec_ok));

   assert_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
      trap_hit |=> (fld_src == $past(ins_word[14:13]) && fld_dst == $past(ins_word[12:11])
                    && fld_num == $past(ins_word[10:4])));

   assert_save_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      trap_hit |=> (mem_req && mem_we && mem_addr == SAVE_A
                    && mem_wdata == 16'($past(ins_addr))));

   assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

   assert_vector_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we && mem_addr == VEC_A));

   assert_pc_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack) |=> (pc_load && pc_value == $past(mem_rdata[AW-1:0])));

   assert_pc_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> (!pc_load && !busy));

   assert_busy_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!trap_hit && !exec_ok));

   assert_busy_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(fld_src) && $stable(fld_dst) && $stable(fld_num)));

endmodule

bind rtrap_detect rtrap_checker #(
   .AW       (AW),
   .SAVE_LOC (SAVE_LOC),
   .VEC_LOC  (VEC_LOC)
) i_rtrap_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .ins_word  (ins_word),
   .ins_addr  (ins_addr),
   .trap_hit  (trap_hit),
   .exec_ok   (exec_ok),
   .busy      (busy),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack),
   .mem_rdata (mem_rdata),
   .pc_load   (pc_load),
   .pc_value  (pc_value),
   .fld_src   (fld_src),
   .fld_dst   (fld_dst),
   .fld_num   (fld_num)
);

// File: tb/test_rtrap_detect.sv
`timescale 1ns/1ps
module test_rtrap_detect;

   localparam int AW = 15;
   localparam logic [AW-1:0] MASK = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ins_valid = 1'b0;
   logic [15:0]   ins_word = '0;
   logic [AW-1:0] ins_addr = '0;
   logic          trap_hit, exec_ok, busy, mem_req, mem_we, pc_load;
   logic [AW-1:0] mem_addr, pc_value;
   logic [15:0]   mem_wdata;
   logic          mem_ack = 1'b0;
   logic [15:0]   mem_rdata = '0;
   logic [1:0]    fld_src, fld_dst;
   logic [6:0]    fld_num;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [1:0] e_src = '0;
   logic [1:0] e_dst = '0;
   logic [6:0] e_num = '0;

   always #2.5 clk = ~clk;

   rtrap_detect #(.AW(AW)) i_rtrap_detect (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
      .ins_addr(ins_addr), .trap_hit(trap_hit), .exec_ok(exec_ok), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .pc_load(pc_load), .pc_value(pc_value),
      .fld_src(fld_src), .fld_dst(fld_dst), .fld_num(fld_num)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_fields(input string req);
      chk({fld_src, fld_dst, fld_num} == {e_src, e_dst, e_num}, req,
          {21'd0, fld_src, fld_dst, fld_num}, {21'd0, e_src, e_dst, e_num});
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog R6 actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R8: reset state
      chk(busy == 1'b0, "R8 busy", busy, 0);
      chk(mem_req == 1'b0, "R8 mem_req", mem_req, 0);
      chk(pc_load == 1'b0, "R8 pc_load", pc_load, 0);
      chk_fields("R8 fields");
      rst_n = 1'b1;
      tick();

      for (int w = 0; w < 65536; w++) begin
         logic [15:0]   iw;
         logic [AW-1:0] a;
         logic [15:0]   v;
         bit            is_trap;
         int            k1;
         int            k2;
         iw = w[15:0];
         a  = AW'((w * 13 + 5)) & MASK;
         v  = {iw[7:0], iw[15:8]} ^ 16'h5a5a;
         is_trap = iw[15] && iw[3] && (iw[2:0] == 3'b000);
         k1 = (w >> 4) % 3;
         k2 = (w >> 6) % 3;

         // R3/R7: fields hold their last trapped value
         chk_fields("R3 hold");

         if (is_trap) begin
            // R1: a trap word without valid is not accepted
            ins_valid = 1'b0; ins_word = iw; ins_addr = a;
            #1;
            chk(trap_hit == 1'b0, "R1 invalid", trap_hit, 0);
            chk(exec_ok == 1'b0, "R2 invalid", exec_ok, 0);
            ins_valid = 1'b1;
            #1;
            chk(trap_hit == 1'b1, "R1 trap", trap_hit, 1);
            chk(exec_ok == 1'b0, "R2 trap", exec_ok, 0);
            tick();
            e_src = iw[14:13]; e_dst = iw[12:11]; e_num = iw[10:4];
            // R7: another trap word presented while busy is ignored
            ins_word = 16'hfff8; ins_addr = ~a;
            #1;
            chk(busy == 1'b1, "R7 busy", busy, 1);
            chk(trap_hit == 1'b0, "R7 no hit", trap_hit, 0);
            chk(exec_ok == 1'b0, "R7 no exec", exec_ok, 0);
            chk_fields("R3 latch");
            for (int i = 0; i <= k1; i++) begin
               // R4: save write, held through wait states
               chk(mem_req && mem_we, "R4 write", {mem_req, mem_we}, 2'b11);
               chk(mem_addr == AW'('o46), "R4 addr", mem_addr, 'o46);
               chk(mem_wdata == 16'(a), "R4 wdata", mem_wdata, 16'(a));
               if (i < k1) tick();
            end
            mem_ack = 1'b1;
            tick();
            mem_ack = 1'b0;
            for (int i = 0; i <= k2; i++) begin
               // R5: vector read, held through wait states
               chk(mem_req && !mem_we, "R5 read", {mem_req, mem_we}, 2'b10);
               chk(mem_addr == AW'('o47), "R5 addr", mem_addr, 'o47);
               if (i < k2) tick();
            end
            mem_ack = 1'b1; mem_rdata = v;
            tick();
            mem_ack = 1'b0; mem_rdata = ~v; ins_valid = 1'b0;
            // R6: program counter load
            chk(pc_load == 1'b1, "R6 pc_load", pc_load, 1);
            chk(pc_value == v[AW-1:0], "R6 pc_value", pc_value, v[AW-1:0]);
            chk(mem_req == 1'b0, "R6 no req", mem_req, 0);
            chk(busy == 1'b1, "R7 busy load", busy, 1);
            tick();
            chk(pc_load == 1'b0, "R6 pulse", pc_load, 0);
            chk(busy == 1'b0, "R6 idle", busy, 0);
            chk_fields("R7 ignored");
         end else begin
            ins_valid = 1'b1; ins_word = iw; ins_addr = a;
            #1;
            chk(trap_hit == 1'b0, "R1 nontrap", trap_hit, 0);
            chk(exec_ok == 1'b1, "R2 exec", exec_ok, 1);
            tick();
            chk(busy == 1'b0, "R2 stays idle", busy, 0);
         end
      end

      ins_valid = 1'b0;
      tick();
      chk_fields("R3 final");
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule